// File: doc/BRIEF.md
# Timed Waveform Line Sequencer

The sequencer runs a stream of waveform lines handed to it over a valid/ready input. Each line names which of two downstream executors receives its payload, how many time units it lasts, and a time-scaling exponent. The exponent stretches every time unit to 2**shift clocks. Flags on the line can ask the block to wait for an external trigger before the line starts or after it ends. They can also raise the AUX and DAC-silence outputs while the line runs, request a phase-accumulator clear at the start, and signal a jump at the end.

While a line runs, the block gives the selected executor a one-cycle load strobe. It emits an evolve enable once every 2**shift clocks and uses that same enable to count down the duration. It accepts the next line only after the current one has finished. The two executor outputs come back as 16-bit signed values. The block adds them, saturates the sum, and registers the result as the DAC sample.

Top module: `line_sequencer`

## Requirements
- R1: `line_ready` is high only when no line is pending or running and `arm` is high. A line is taken on a clock edge where both `line_valid` and `line_ready` are high. While `arm` is low, no line is taken.
- R2: A line with `line_trig`=1 does not start until a clock edge where both `trigger` and `arm` are high. Its load strobe appears in the cycle after that edge. A line without the flag starts in the cycle after it is taken.
- R3: While a line runs, `evolve` pulses once every 2**`line_shift` clocks. The first pulse falls in running cycle 2**shift, where running cycle 1 is the line's first running cycle.
- R4: A line runs for max(`line_dur`,1) * 2**`line_shift` cycles and gives exactly max(`line_dur`,1) evolve pulses. A duration of 0 counts as 1. `line_ready` rises in the cycle after the last evolve pulse.
- R5: A line with `line_hold`=1 keeps `line_ready` low after it ends, until a clock edge where both `trigger` and `arm` are high.
- R6: `line_sel`=0 picks executor A and `line_sel`=1 picks executor B. The picked executor gets a single-cycle load strobe (`load_a` or `load_b`) in running cycle 1. The other executor's strobe stays low. `payload_out` carries the line's payload at that time.
- R7: `aux_out` and `silence_out` are high in every running cycle of a line whose `line_aux` or `line_silence` flag, respectively, is set. They are low at all other times.
- R8: `phase_clear` pulses for one cycle in running cycle 1 when `line_clear` is set, and never otherwise.
- R9: `jump_out` pulses for one cycle in the last running cycle when `line_jump` is set, and never otherwise.
- R10: `sample_out` equals `exec_a + exec_b` as signed 16-bit values, clamped to [-32768, 32767]. It appears one clock after the inputs are sampled.
- R11: A `trigger` pulse while `arm` is low has no effect on a line waiting for its trigger.
- R12: After reset the block is idle. `load_a`, `load_b`, `evolve`, `aux_out`, `silence_out`, `phase_clear` and `jump_out` are low, and `sample_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Enables line acceptance and trigger response |
| trigger | input | 1 | External trigger |
| line_valid | input | 1 | A line is offered |
| line_ready | output | 1 | The block takes the offered line |
| line_dur | input | DUR_W | Duration in evolve periods |
| line_shift | input | SHIFT_W | Time-scaling exponent |
| line_sel | input | 1 | Executor select: 0 = A, 1 = B |
| line_trig | input | 1 | Wait for trigger before this line |
| line_hold | input | 1 | Wait for trigger before the next line |
| line_silence | input | 1 | Silence the DAC clocks during this line |
| line_aux | input | 1 | Raise AUX during this line |
| line_jump | input | 1 | Signal a jump at the end of this line |
| line_clear | input | 1 | Request a phase clear at line start |
| line_payload | input | PAY_W | Opaque executor data |
| exec_a | input | 16 | Executor A output, signed |
| exec_b | input | 16 | Executor B output, signed |
| payload_out | output | PAY_W | Payload of the current line |
| load_a | output | 1 | Load strobe for executor A |
| load_b | output | 1 | Load strobe for executor B |
| evolve | output | 1 | Evolve enable for the executors |
| phase_clear | output | 1 | Phase accumulator clear request |
| jump_out | output | 1 | Jump indication at line end |
| aux_out | output | 1 | AUX TTL output |
| silence_out | output | 1 | DAC clock silence |
| sample_out | output | 16 | Saturated sum of the executor outputs |

## Verification
On every cycle, the assertions check the following:
- the two load strobes never fire together, and each lasts a single cycle;
- a line waiting for its trigger, or a finished hold line, stays put without an armed trigger;
- AUX never overlaps acceptance;
- evolve pulses are spaced apart whenever the shift is nonzero;
- the duration counter never runs dry while a line runs;
- the sum of two non-negative samples never comes out negative.

Only the bench scenarios can show the exact cycle counts, which need whole-line observation:
- a run length of max(D,1)·2**S;
- where the first evolve and the load strobe fall;
- the position of the jump pulse;
- the clamped sums at the extremes;
- that an unarmed trigger leaves a pending line untouched.

// File: rtl/lsq_pkg.sv
// Shared types for the line sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package lsq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRIG = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } lsq_state_e;

    typedef struct packed {
        logic sel;
        logic trig;
        logic hold;
        logic silence;
        logic aux;
        logic jump;
        logic clear;
    } lsq_flags_t;

endpackage

// File: rtl/lsq_timebase.sv
// Prescaler and duration counter for one running line.
// The prescaler produces evolve once every 2**shift clocks while run is high.
// Each evolve decrements the duration counter, and last marks the final evolve.
// Assumes: start and run are never high together, and shift is stable while run is high.
module lsq_timebase #(
    parameter int SHIFT_W = 3,
    parameter int DUR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [DUR_W-1:0]   dur_load,
    output logic               evolve,
    output logic               last
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;
    logic [DUR_W-1:0] left_q;

    assign mask   = ~({PRE_W{1'b1}} << shift);
    assign evolve = run && (pre_q == mask);
    assign last   = evolve && (left_q == DUR_W'(1));

    // Prescaler: restarts at line start and wraps after each evolve.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (start)  pre_q <= '0;
        else if (run)    pre_q <= evolve ? '0 : pre_q + PRE_W'(1);
    end

    // Duration counter: loads max(dur,1) at start and counts evolve pulses down.
    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (start)  left_q <= (dur_load == '0) ? DUR_W'(1) : dur_load;
        else if (evolve) left_q <= left_q - DUR_W'(1);
    end

    a_r3_evolve_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (evolve && mask != '0) |=> !evolve);

    a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (left_q != '0));

endmodule

// File: rtl/lsq_sat_add.sv
// Registered saturating adder for two signed samples.
// Assumes: both operands share the same width W.
module lsq_sat_add #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;
    assign sum = {a[W-1], a} + {b[W-1], b};

    // Clamp on overflow in either direction and register the result.
    always_ff @(posedge clk) begin
        if (!rst_n)                  y <= '0;
        else if (sum[W:W-1] == 2'b01) y <= MAXV;
        else if (sum[W:W-1] == 2'b10) y <= MINV;
        else                          y <= sum[W-1:0];
    end

    a_r10_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (!a[W-1] && !b[W-1]) |=> !y[W-1]);

endmodule

// File: rtl/line_sequencer.sv
// Top of the timed waveform line sequencer.
// It takes lines over valid/ready, gates them on trigger flags, strobes the
// selected executor, runs the timebase, and drives the per-line outputs.
// Assumes: the executors consume load_a/load_b/evolve on the same clock.
module line_sequencer
    import lsq_pkg::*;
#(
    parameter int SHIFT_W = 3,
    parameter int DUR_W   = 16,
    parameter int PAY_W   = 32,
    parameter int SMP_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm,
    input  logic                    trigger,
    input  logic                    line_valid,
    output logic                    line_ready,
    input  logic [DUR_W-1:0]        line_dur,
    input  logic [SHIFT_W-1:0]      line_shift,
    input  logic                    line_sel,
    input  logic                    line_trig,
    input  logic                    line_hold,
    input  logic                    line_silence,
    input  logic                    line_aux,
    input  logic                    line_jump,
    input  logic                    line_clear,
    input  logic [PAY_W-1:0]        line_payload,
    input  logic signed [SMP_W-1:0] exec_a,
    input  logic signed [SMP_W-1:0] exec_b,
    output logic [PAY_W-1:0]        payload_out,
    output logic                    load_a,
    output logic                    load_b,
    output logic                    evolve,
    output logic                    phase_clear,
    output logic                    jump_out,
    output logic                    aux_out,
    output logic                    silence_out,
    output logic signed [SMP_W-1:0] sample_out
);
    lsq_state_e           state_q;
    lsq_flags_t           flags_q;
    logic [SHIFT_W-1:0]   shift_q;
    logic [DUR_W-1:0]     dur_q;
    logic [PAY_W-1:0]     payload_q;
    logic                 first_q;
    logic                 accept;
    logic                 go_trig;
    logic                 start;
    logic                 running;
    logic                 last;
    logic [DUR_W-1:0]     dur_src;

    assign line_ready = arm && (state_q == ST_IDLE);
    assign accept     = line_valid && line_ready;
    assign go_trig    = (state_q == ST_TRIG) && trigger && arm;
    assign start      = (accept && !line_trig) || go_trig;
    assign running    = (state_q == ST_RUN);
    assign dur_src    = (state_q == ST_IDLE) ? line_dur : dur_q;

    // Capture the line fields when a line is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q   <= '0;
            shift_q   <= '0;
            dur_q     <= '0;
            payload_q <= '0;
        end else if (accept) begin
            flags_q   <= '{sel: line_sel, trig: line_trig, hold: line_hold,
                           silence: line_silence, aux: line_aux,
                           jump: line_jump, clear: line_clear};
            shift_q   <= line_shift;
            dur_q     <= line_dur;
            payload_q <= line_payload;
        end
    end

    // Line state machine: idle, waiting for trigger, running, holding.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE: if (accept)  state_q <= line_trig ? ST_TRIG : ST_RUN;
                ST_TRIG: if (go_trig) state_q <= ST_RUN;
                ST_RUN:  if (last)    state_q <= flags_q.hold ? ST_HOLD : ST_IDLE;
                ST_HOLD: if (trigger && arm) state_q <= ST_IDLE;
                default:              state_q <= ST_IDLE;
            endcase
        end
    end

    // Mark the first running cycle of a line.
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= start;
    end

    lsq_timebase #(.SHIFT_W(SHIFT_W), .DUR_W(DUR_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .run      (running),
        .shift    (shift_q),
        .dur_load (dur_src),
        .evolve   (evolve),
        .last     (last)
    );

    lsq_sat_add #(.W(SMP_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (exec_a),
        .b     (exec_b),
        .y     (sample_out)
    );

    assign payload_out = payload_q;
    assign load_a      = first_q && !flags_q.sel;
    assign load_b      = first_q &&  flags_q.sel;
    assign phase_clear = first_q && flags_q.clear;
    assign jump_out    = last && flags_q.jump;
    assign aux_out     = running && flags_q.aux;
    assign silence_out = running && flags_q.silence;

    a_r1_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q != ST_IDLE));

    a_r6_one_executor: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_a, load_b}));

    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a || load_b) |=> !(load_a || load_b));

    a_r2_trig_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIG && !(trigger && arm)) |=> (state_q == ST_TRIG));

    a_r5_hold_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !(trigger && arm)) |=> !line_ready);

    a_r7_aux_busy: assert property (@(posedge clk) disable iff (!rst_n)
        aux_out |-> !line_ready);

endmodule

// File: tb/tb_line_sequencer.sv
module tb_line_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b1, trigger = 1'b0, line_valid = 1'b0;
    logic line_ready;
    logic [15:0] line_dur = '0;
    logic [2:0]  line_shift = '0;
    logic line_sel = 0, line_trig = 0, line_hold = 0, line_silence = 0;
    logic line_aux = 0, line_jump = 0, line_clear = 0;
    logic [31:0] line_payload = '0;
    logic signed [15:0] exec_a = '0, exec_b = '0;
    logic [31:0] payload_out;
    logic load_a, load_b, evolve, phase_clear, jump_out, aux_out, silence_out;
    logic signed [15:0] sample_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    line_sequencer dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trigger(trigger),
        .line_valid(line_valid), .line_ready(line_ready),
        .line_dur(line_dur), .line_shift(line_shift), .line_sel(line_sel),
        .line_trig(line_trig), .line_hold(line_hold),
        .line_silence(line_silence), .line_aux(line_aux),
        .line_jump(line_jump), .line_clear(line_clear),
        .line_payload(line_payload), .exec_a(exec_a), .exec_b(exec_b),
        .payload_out(payload_out), .load_a(load_a), .load_b(load_b),
        .evolve(evolve), .phase_clear(phase_clear), .jump_out(jump_out),
        .aux_out(aux_out), .silence_out(silence_out), .sample_out(sample_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Offer one line (no trigger gating) and observe it until ready returns.
    task automatic run_line(input int d, input int s, input bit sel, input bit ax,
                            input bit sl, input bit jp, input bit cl);
        int idx, n_ev, first_ev, bad_ev, n_la, n_lb, la_at, lb_at;
        int n_aux, n_sil, n_clr, clr_at, n_jmp, jmp_at, dn, exp_run;
        logic [31:0] pay, pay_seen;
        pay = 32'hA500_0000 | (s << 8) | d;
        @(negedge clk);
        line_dur = 16'(d); line_shift = 3'(s); line_sel = sel;
        line_trig = 0; line_hold = 0; line_aux = ax; line_silence = sl;
        line_jump = jp; line_clear = cl; line_payload = pay; line_valid = 1;
        chk(line_ready == 1'b1, "R1 ready when idle and armed", int'(line_ready), 1);
        @(negedge clk);
        line_valid = 0;
        idx = 1; n_ev = 0; first_ev = 0; bad_ev = 0; n_la = 0; n_lb = 0;
        la_at = 0; lb_at = 0; n_aux = 0; n_sil = 0; n_clr = 0; clr_at = 0;
        n_jmp = 0; jmp_at = 0; pay_seen = '0;
        while (!line_ready && idx < 5000) begin
            if (evolve) begin
                n_ev++;
                if (first_ev == 0) first_ev = idx;
                if ((idx % (1 << s)) != 0) bad_ev++;
            end
            if (load_a) begin n_la++; la_at = idx; pay_seen = payload_out; end
            if (load_b) begin n_lb++; lb_at = idx; pay_seen = payload_out; end
            if (aux_out) n_aux++;
            if (silence_out) n_sil++;
            if (phase_clear) begin n_clr++; clr_at = idx; end
            if (jump_out) begin n_jmp++; jmp_at = idx; end
            idx++;
            @(negedge clk);
        end
        dn = (d == 0) ? 1 : d;
        exp_run = dn << s;
        chk(idx - 1 == exp_run, "R4 running length", idx - 1, exp_run);
        chk(n_ev == dn, "R4 evolve count", n_ev, dn);
        chk(first_ev == (1 << s), "R3 first evolve position", first_ev, 1 << s);
        chk(bad_ev == 0, "R3 evolve spacing", bad_ev, 0);
        chk((sel ? n_lb : n_la) == 1, "R6 selected load count", sel ? n_lb : n_la, 1);
        chk((sel ? n_la : n_lb) == 0, "R6 other load silent", sel ? n_la : n_lb, 0);
        chk((sel ? lb_at : la_at) == 1, "R6 load in first cycle", sel ? lb_at : la_at, 1);
        chk(pay_seen == pay, "R6 payload", int'(pay_seen), int'(pay));
        chk(n_aux == (ax ? exp_run : 0), "R7 aux cycles", n_aux, ax ? exp_run : 0);
        chk(n_sil == (sl ? exp_run : 0), "R7 silence cycles", n_sil, sl ? exp_run : 0);
        chk(n_clr == int'(cl), "R8 clear count", n_clr, int'(cl));
        if (cl) chk(clr_at == 1, "R8 clear position", clr_at, 1);
        chk(n_jmp == int'(jp), "R9 jump count", n_jmp, int'(jp));
        if (jp) chk(jmp_at == exp_run, "R9 jump position", jmp_at, exp_run);
    endtask

    initial begin
        int vals[8];
        int exp_s, cnt;
        vals = '{0, 1, -1, 32767, -32768, 20000, -20000, 12345};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk(line_ready == 1'b1, "R12 idle after reset", int'(line_ready), 1);
        chk({load_a, load_b, evolve, aux_out, silence_out, phase_clear, jump_out} == 7'b0,
            "R12 outputs low", int'({load_a, load_b, evolve, aux_out, silence_out,
            phase_clear, jump_out}), 0);
        chk(sample_out == 16'sd0, "R12 sample zero", int'(sample_out), 0);

        // R3, R4, R6..R9 sweep over shift and duration
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 4; d++)
                run_line(d, s, (d + s) % 2 == 1, d[0], s[0], s[1], d[1]);

        // R1: disarmed, no line is taken
        @(negedge clk);
        arm = 0; line_valid = 1; line_trig = 0; line_hold = 0; line_aux = 1;
        line_dur = 16'd1; line_shift = 3'd0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (line_ready || aux_out || load_a || load_b) cnt++;
        end
        chk(cnt == 0, "R1 no accept while disarmed", cnt, 0);
        line_valid = 0; arm = 1;

        // R2, R11: trigger-gated line
        @(negedge clk);
        line_dur = 16'd2; line_shift = 3'd1; line_sel = 1; line_trig = 1;
        line_aux = 1; line_valid = 1;
        @(negedge clk);
        line_valid = 0; line_trig = 0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            if (load_b || aux_out || line_ready) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R2 line waits for trigger", cnt, 0);
        arm = 0; trigger = 1;
        @(negedge clk);
        trigger = 0;
        @(negedge clk);
        chk(load_b == 1'b0 && aux_out == 1'b0, "R11 unarmed trigger ignored",
            int'(load_b), 0);
        arm = 1; trigger = 1;
        @(negedge clk);
        trigger = 0;
        chk(load_b == 1'b1, "R2 load after trigger", int'(load_b), 1);
        cnt = 0;
        while (!line_ready && cnt < 100) begin cnt++; @(negedge clk); end
        chk(cnt == 4, "R2 triggered line length", cnt, 4);

        // R5: hold line blocks the next one until trigger
        line_dur = 16'd1; line_shift = 3'd0; line_hold = 1; line_aux = 0;
        line_valid = 1;
        @(negedge clk);
        line_valid = 0; line_hold = 0;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 3; i++) begin
            if (line_ready) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R5 ready held low", cnt, 0);
        trigger = 1;
        @(negedge clk);
        trigger = 0;
        chk(line_ready == 1'b1, "R5 ready after trigger", int'(line_ready), 1);

        // R10: saturating sum sweep
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                exec_a = 16'(vals[i]); exec_b = 16'(vals[j]);
                exp_s = vals[i] + vals[j];
                if (exp_s > 32767) exp_s = 32767;
                if (exp_s < -32768) exp_s = -32768;
                @(negedge clk);
                chk(int'(sample_out) == exp_s, "R10 saturated sum", int'(sample_out), exp_s);
            end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule